// File: doc/BRIEF.md
# Fully Interlocked Byte Handshake Link

This block carries bytes between two clock domains using a level-sensitive, four-phase request/acknowledge exchange. A transmitting end accepts a byte on a local valid/ready port, pulls an active-low request line down, and waits for the far end to answer. A receiving end raises its acknowledge once it has room, and the transmitter only then places the byte on the shared data lines. The transmitter then lets the request line go high to mark the data as valid.

The receiving end latches the data lines when it sees the request return high. It then lowers its acknowledge and offers the byte on its own valid/ready port. A new request may not start until the acknowledge is seen low again. Each end runs on its own clock and resynchronises the other end's control line through a chain of flops before acting on it. The three wire-level lines are brought out so that the link can be observed.

Top module: `hs_link`

## Requirements
- R1: After reset the request line `link_strobe_n` is 1 (inactive), `link_ack` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: `link_strobe_n` falls only in the tx cycle after a byte has been accepted (`tx_valid` and `tx_ready` both 1). `tx_ready` stays 0 while the request line is low.
- R3: The receiving end raises `link_ack` only while `rx_valid` is 0. With `rx_ready` held at 0 and a byte still buffered, a new request stays unanswered: `link_strobe_n` stays 0 and `link_ack` stays 0.
- R4: `link_bus` changes only while `link_strobe_n` is 0. It keeps its value from the release of the request until the next request.
- R5: `link_strobe_n` returns to 1 only while `link_ack` is 1, which means the data is launched after the acknowledge.
- R6: `link_ack` falls only when the captured byte is presented (`rx_valid` 1). A presented byte and `rx_valid` hold until `rx_ready` is 1.
- R7: A new request (`link_strobe_n` falling) starts only while `link_ack` is 0.
- R8: `link_ack` rises only while `link_strobe_n` is 0.
- R9: Every accepted byte appears exactly once at `rx_data`, in acceptance order, with its value unchanged, for any of the 256 byte values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmitting-end clock |
| tx_rst | input | 1 | Synchronous active-high reset, transmitting end |
| tx_valid | input | 1 | Local byte offered for sending |
| tx_ready | output | 1 | Transmitting end can take a byte |
| tx_data | input | DATA_W | Local byte to send |
| rx_clk | input | 1 | Receiving-end clock |
| rx_rst | input | 1 | Synchronous active-high reset, receiving end |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Local consumer takes the byte |
| rx_data | output | DATA_W | Received byte |
| link_strobe_n | output | 1 | Active-low request line on the link |
| link_ack | output | 1 | Acknowledge line on the link |
| link_bus | output | DATA_W | Data lines on the link |

## Verification
The bench builds the link with its defaults: an 8-bit path and two resynchronising flops on each control line. The transmitting clock has an 8 ns period and the receiving clock a 14 ns period. Because the two periods are unrelated, the request and acknowledge edges land at shifting phases of the other clock, so the interlock is exercised across many crossing alignments and not at one fixed offset. The 8-bit width puts the extreme byte values 0x00 and 0xFF within reach of a short directed stream. Holding the consumer off makes the transmitting end sit on an unanswered request, which exposes the backpressure path.

// File: rtl/hs_link_pkg.sv
`timescale 1ns/1ps
package hs_link_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_REQ   = 2'd1,
        TX_DRIVE = 2'd2,
        TX_HOLD  = 2'd3
    } tx_state_e;

    typedef enum logic {
        RX_WAIT = 1'b0,
        RX_ACKD = 1'b1
    } rx_state_e;

    localparam int MIN_SYNC_STAGES = 2;

    // The transmitting end may take a new byte only when idle and the far end has let go.
    function automatic logic tx_can_accept(tx_state_e st, logic ack_seen);
        return (st == TX_IDLE) && !ack_seen;
    endfunction

    // The receiving end may answer a request only when its output buffer is empty.
    function automatic logic rx_can_answer(logic req_seen_n, logic buf_full);
        return !req_seen_n && !buf_full;
    endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int NS = (STAGES < hs_link_pkg::MIN_SYNC_STAGES) ?
                        hs_link_pkg::MIN_SYNC_STAGES : STAGES;

    logic [NS-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {NS{RST_VAL}};
        else     chain <= {chain[NS-2:0], d};
    end

    assign q = chain[NS-1];
endmodule

// File: rtl/hs_sender.sv
`timescale 1ns/1ps
module hs_sender
    import hs_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_async,
    output logic              strobe_n,
    output logic [DATA_W-1:0] bus
);
    tx_state_e         state;
    logic              ack_seen;
    logic [DATA_W-1:0] hold_q;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) ack_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (ack_async),
        .q   (ack_seen)
    );

    assign in_ready = tx_can_accept(state, ack_seen);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            strobe_n <= 1'b1;
            bus      <= '0;
            hold_q   <= '0;
        end else begin
            unique case (state)
                TX_IDLE: if (in_valid && in_ready) begin
                    hold_q   <= in_data;
                    strobe_n <= 1'b0;
                    state    <= TX_REQ;
                end
                TX_REQ: if (ack_seen) begin
                    bus   <= hold_q;
                    state <= TX_DRIVE;
                end
                TX_DRIVE: begin
                    strobe_n <= 1'b1;
                    state    <= TX_HOLD;
                end
                TX_HOLD: if (!ack_seen) state <= TX_IDLE;
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs_receiver.sv
`timescale 1ns/1ps
module hs_receiver
    import hs_link_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_n_async,
    input  logic [DATA_W-1:0] bus,
    output logic              ack,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    rx_state_e state;
    logic      req_seen_n;

    hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) strobe_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (strobe_n_async),
        .q   (req_seen_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_WAIT;
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            unique case (state)
                RX_WAIT: if (rx_can_answer(req_seen_n, out_valid)) begin
                    ack   <= 1'b1;
                    state <= RX_ACKD;
                end
                RX_ACKD: if (req_seen_n) begin
                    out_data  <= bus;
                    out_valid <= 1'b1;
                    ack       <= 1'b0;
                    state     <= RX_WAIT;
                end
                default: state <= RX_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/hs_link.sv
`timescale 1ns/1ps
module hs_link #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              tx_clk,
    input  logic              tx_rst,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_clk,
    input  logic              rx_rst,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              link_strobe_n,
    output logic              link_ack,
    output logic [DATA_W-1:0] link_bus
);
    hs_sender #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) sender_i (
        .clk       (tx_clk),
        .rst       (tx_rst),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .in_data   (tx_data),
        .ack_async (link_ack),
        .strobe_n  (link_strobe_n),
        .bus       (link_bus)
    );

    hs_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) receiver_i (
        .clk            (rx_clk),
        .rst            (rx_rst),
        .strobe_n_async (link_strobe_n),
        .bus            (link_bus),
        .ack            (link_ack),
        .out_valid      (rx_valid),
        .out_ready      (rx_ready),
        .out_data       (rx_data)
    );
endmodule

// File: rtl/hs_link_chk.sv
`timescale 1ns/1ps
module hs_link_chk #(
    parameter int DATA_W = 8
) (
    input logic              tx_clk,
    input logic              tx_rst,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_clk,
    input logic              rx_rst,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              link_strobe_n,
    input logic              link_ack,
    input logic [DATA_W-1:0] link_bus
);
    p_reset_idle_r1: assert property (@(posedge tx_clk)
        tx_rst |=> link_strobe_n);

    p_reset_empty_r1: assert property (@(posedge rx_clk)
        rx_rst |=> (!rx_valid && !link_ack));

    p_req_after_accept_r2: assert property (@(posedge tx_clk) disable iff (tx_rst)
        $fell(link_strobe_n) |-> $past(tx_valid && tx_ready));

    p_busy_not_ready_r2: assert property (@(posedge tx_clk) disable iff (tx_rst)
        !link_strobe_n |-> !tx_ready);

    p_ack_needs_room_r3: assert property (@(posedge rx_clk) disable iff (rx_rst)
        $rose(link_ack) |-> !rx_valid);

    p_bus_stable_r4: assert property (@(posedge tx_clk) disable iff (tx_rst)
        (link_strobe_n && $past(link_strobe_n)) |-> $stable(link_bus));

    p_release_after_ack_r5: assert property (@(posedge tx_clk) disable iff (tx_rst)
        $rose(link_strobe_n) |-> link_ack);

    p_drop_ack_captured_r6: assert property (@(posedge rx_clk) disable iff (rx_rst)
        $fell(link_ack) |-> rx_valid);

    p_hold_output_r6: assert property (@(posedge rx_clk) disable iff (rx_rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    p_new_req_ack_low_r7: assert property (@(posedge tx_clk) disable iff (tx_rst)
        $fell(link_strobe_n) |-> !link_ack);

    p_ack_needs_req_r8: assert property (@(posedge rx_clk) disable iff (rx_rst)
        $rose(link_ack) |-> !link_strobe_n);
endmodule

bind hs_link hs_link_chk #(.DATA_W(DATA_W)) chk_i (
    .tx_clk        (tx_clk),
    .tx_rst        (tx_rst),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .rx_clk        (rx_clk),
    .rx_rst        (rx_rst),
    .rx_valid      (rx_valid),
    .rx_ready      (rx_ready),
    .rx_data       (rx_data),
    .link_strobe_n (link_strobe_n),
    .link_ack      (link_ack),
    .link_bus      (link_bus)
);

// File: tb/hs_link_tb_top.sv
`timescale 1ns/1ps
module hs_link_tb_top;
    localparam int DW = 8;

    logic          tx_clk = 1'b0;
    logic          rx_clk = 1'b0;
    logic          tx_rst = 1'b1;
    logic          rx_rst = 1'b1;
    logic          tx_valid = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic          rx_ready = 1'b0;
    logic          tx_ready, rx_valid, link_strobe_n, link_ack;
    logic [DW-1:0] rx_data, link_bus;

    int n_chk  = 0;
    int n_fail = 0;

    logic [DW-1:0] got [0:63];
    int            got_n = 0;
    logic [DW-1:0] sent [0:63];
    int            sent_n = 0;

    int            bus_viol = 0;
    int            rel_viol = 0;
    logic          prev_strobe_n = 1'b1;
    logic [DW-1:0] prev_bus = '0;

    always #4 tx_clk = ~tx_clk;
    always #7 rx_clk = ~rx_clk;

    hs_link #(.DATA_W(DW), .SYNC_STAGES(2)) dut_i (
        .tx_clk        (tx_clk),
        .tx_rst        (tx_rst),
        .tx_valid      (tx_valid),
        .tx_ready      (tx_ready),
        .tx_data       (tx_data),
        .rx_clk        (rx_clk),
        .rx_rst        (rx_rst),
        .rx_valid      (rx_valid),
        .rx_ready      (rx_ready),
        .rx_data       (rx_data),
        .link_strobe_n (link_strobe_n),
        .link_ack      (link_ack),
        .link_bus      (link_bus)
    );

    // Collect bytes handed over at the receiving port.
    always @(negedge rx_clk) begin
        if (!rx_rst && rx_valid && rx_ready && got_n < 64) begin
            got[got_n] = rx_data;
            got_n++;
        end
    end

    // Line-level observation on the transmitting side (R4, R5).
    always @(negedge tx_clk) begin
        if (!tx_rst) begin
            if (link_strobe_n && prev_strobe_n && link_bus !== prev_bus) bus_viol++;
            if (link_strobe_n && !prev_strobe_n && !link_ack) rel_viol++;
        end
        prev_strobe_n = link_strobe_n;
        prev_bus      = link_bus;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic send_byte(input logic [DW-1:0] b);
        @(negedge tx_clk);
        tx_valid = 1'b1;
        tx_data  = b;
        while (!tx_ready) @(negedge tx_clk);
        @(negedge tx_clk);
        tx_valid = 1'b0;
        sent[sent_n] = b;
        sent_n++;
    endtask

    task automatic wait_got(input int n);
        while (got_n < n) @(negedge rx_clk);
    endtask

    task automatic test_reset();
        repeat (4) @(posedge rx_clk);
        @(posedge tx_clk); #1 tx_rst = 1'b0;
        @(posedge rx_clk); #1 rx_rst = 1'b0;
        @(negedge tx_clk);
        check(link_strobe_n === 1'b1, "R1 strobe idle", link_strobe_n, 1);
        check(tx_ready === 1'b1, "R1 tx_ready", tx_ready, 1);
        @(negedge rx_clk);
        check(link_ack === 1'b0, "R1 ack low", link_ack, 0);
        check(rx_valid === 1'b0, "R1 rx_valid low", rx_valid, 0);
    endtask

    task automatic test_single();
        int base = got_n;
        @(posedge rx_clk); #1 rx_ready = 1'b1;
        send_byte(8'h3C);
        // send_byte returns at the first negedge after acceptance
        check(link_strobe_n === 1'b0, "R2 request raised", link_strobe_n, 0);
        check(tx_ready === 1'b0, "R2 busy not ready", tx_ready, 0);
        wait_got(base + 1);
        check(got[base] === 8'h3C, "R9 single byte", got[base], 8'h3C);
        repeat (8) @(negedge tx_clk);
        check(link_strobe_n === 1'b1 && link_ack === 1'b0, "R7 link back to idle",
              {link_strobe_n, link_ack}, 2'b10);
        check(tx_ready === 1'b1, "R7 ready after ack low", tx_ready, 1);
    endtask

    task automatic test_stream();
        int base = got_n;
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] b;
            b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : DW'(i * 37 + 5);
            send_byte(b);
        end
        wait_got(base + 8);
        for (int i = 0; i < 8; i++)
            check(got[base+i] === sent[base+i], "R9 stream order/value",
                  got[base+i], sent[base+i]);
    endtask

    task automatic test_backpressure();
        int base = got_n;
        @(posedge rx_clk); #1 rx_ready = 1'b0;
        send_byte(8'hA5);
        while (!rx_valid) @(negedge rx_clk);
        send_byte(8'h5A);
        repeat (40) @(negedge rx_clk);
        check(link_strobe_n === 1'b0, "R3 request pending", link_strobe_n, 0);
        check(link_ack === 1'b0, "R3 no ack while full", link_ack, 0);
        check(rx_valid === 1'b1 && rx_data === 8'hA5, "R6 first byte held", rx_data, 8'hA5);
        @(posedge rx_clk); #1 rx_ready = 1'b1;
        wait_got(base + 2);
        check(got[base] === 8'hA5, "R9 first after stall", got[base], 8'hA5);
        check(got[base+1] === 8'h5A, "R9 second after stall", got[base+1], 8'h5A);
        repeat (20) @(negedge rx_clk);
        check(got_n == base + 2, "R9 no duplicate", got_n, base + 2);
    endtask

    initial begin
        test_reset();
        test_single();
        test_stream();
        test_backpressure();
        check(bus_viol == 0, "R4 bus stable while released", bus_viol, 0);
        check(rel_viol == 0, "R5 release only with ack", rel_viol, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tx_clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", got_n, sent_n);
        summary();
        $finish;
    end
endmodule